// File: doc/BRIEF.md
# Status and Peak-Level Readout Port

This block is the readout side of a host port on an audio encoder. A host controller fetches bytes one at a time with a read strobe. Each address write from the host moves an internal byte position back to the start. Reads then step through a two-byte status word and four bytes of peak-level data for two audio channels. A read strobe past the last peak byte returns zero until the host writes an address again. A host that polls status repeatedly must therefore write an address before every poll, or it will get peak bytes instead.

For each channel, the block keeps the largest sample magnitude seen, clamped to 15 bits. At a column tick, the running peaks move into a readout snapshot, but only if the host has started a peak read since the last move. The data the host gets therefore covers the previous read period. If the host reads again before a column has passed, it gets the same snapshot again. Each 16-bit peak word carries a valid flag in its least significant bit. A channel with no samples, or a port that has had no snapshot yet, reads as all zeros.

The two status bytes are each sampled at the moment they are read, so they may describe different frames. The high byte holds the bit-rate code, the sample-rate code and the two ready flags that the host polls before it sends new configuration.

Top module: `pkr_readout`

## Requirements
- R1: A cycle with `addr_wr` high sets the read position to the first status byte, whatever the position was before. If `rd_stb` is high in that same cycle, the read is ignored and `rd_data` keeps its value.
- R2: Each accepted read (`rd_stb` high, `addr_wr` low) advances the position through this order: status high, status low, peak byte 0, peak byte 1, peak byte 2, peak byte 3.
- R3: A read accepted after peak byte 3 returns 0x00. The position stays at the end until the next address write.
- R4: The status high byte is {`st_bitrate`[3:0], `st_rate`[1:0], `st_rdy_set`, `st_rdy_ext`}, MSB first. It is sampled in the cycle its read is accepted. Rate codes: 00 = 44.1 kHz, 01 = 48 kHz, 10 = 32 kHz, 11 = reserved. The only legal bit-rate code is 1100.
- R5: The status low byte is {`st_emph`[1:0], `st_misc`[5:0]}. It is sampled in the cycle of its own read, independently of the high byte.
- R6: Channel 0's word is read first, as peak bytes 0 and 1, low byte first. Channel 1's word follows as peak bytes 2 and 3. Within a word, bit 0 is the valid indicator and bits 15:1 hold the 15-bit unsigned peak.
- R7: Each channel's running peak is the maximum of the magnitudes received for that channel (`smp_chan` 0 or 1), each clamped to 32767.
- R8: On `col_tick`, the running peaks move into the snapshot and the running peaks clear, but only if a read of peak byte 0 has been accepted since the last move, or no move has happened since reset. A sample in the same cycle as the tick is included in the move.
- R9: A peak read that happens before a qualifying column tick returns the previous snapshot unchanged.
- R10: A channel with no samples in the moved period, or a port with no snapshot since reset, reads as a word of all zeros.
- R11: From the accepted read of peak byte 0 until the read of peak byte 3 or an address write, no column tick changes the snapshot. A move that is due waits for a later tick.
- R12: `rd_data` is 0 after reset. It updates in the cycle after an accepted read and holds in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_wr | input | 1 | Host address write, rewinds the read position |
| rd_stb | input | 1 | Host byte read strobe |
| col_tick | input | 1 | Column boundary pulse |
| smp_valid | input | 1 | Sample magnitude valid |
| smp_chan | input | 1 | Channel of the sample (0 or 1) |
| smp_mag | input | MAG_W | Unsigned sample magnitude |
| st_bitrate | input | 4 | Bit-rate code |
| st_rate | input | 2 | Sample-rate code |
| st_rdy_set | input | 1 | Ready for settings |
| st_rdy_ext | input | 1 | Ready for extended settings |
| st_emph | input | 2 | Emphasis indication |
| st_misc | input | 6 | Remaining status flags |
| rd_data | output | 8 | Byte returned by the last accepted read |

## Verification
If the read position is wrong, the next accepted read returns a byte from the wrong place in the sequence, or a nonzero byte past the end. This shows up one cycle after the strobe. A wrong move decision, or a running peak that failed to clear, is not visible until the host next reads the peak bytes. It then appears as a stale, merged or missing peak word, so the bench compares every peak read against its own model of the periods. A valid flag set for an empty channel breaks the all-zero invalid pattern on the very read that returns that word.

// File: rtl/pkr_pkg.sv
package pkr_pkg;

  localparam int NUM_CH = 2;
  localparam int WORD_W = 16;

  typedef enum logic [2:0] {
    SQ_ST_HI = 3'd0,
    SQ_ST_LO = 3'd1,
    SQ_PK0   = 3'd2,
    SQ_PK1   = 3'd3,
    SQ_PK2   = 3'd4,
    SQ_PK3   = 3'd5,
    SQ_DONE  = 3'd6
  } seq_pos_t;

  function automatic logic [7:0] status_hi(input logic [3:0] bitrate,
                                           input logic [1:0] rate,
                                           input logic       rdy_set,
                                           input logic       rdy_ext);
    return {bitrate, rate, rdy_set, rdy_ext};
  endfunction

  function automatic logic [7:0] status_lo(input logic [1:0] emph,
                                           input logic [5:0] misc);
    return {emph, misc};
  endfunction

endpackage

// File: rtl/pkr_chan_acc.sv
module pkr_chan_acc #(
  parameter int MAG_W = 16,
  parameter int PK_W  = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hit,
  input  logic [MAG_W-1:0] mag,
  input  logic             clr,
  output logic [PK_W-1:0]  acc_val,
  output logic             acc_seen,
  output logic [PK_W-1:0]  take_val,
  output logic             take_seen
);

  logic [PK_W-1:0] mag_sat;

  function automatic logic [PK_W-1:0] peak_max(input logic [PK_W-1:0] a,
                                               input logic [PK_W-1:0] b);
    return (a > b) ? a : b;
  endfunction

  generate
    if (MAG_W > PK_W) begin : g_sat
      localparam logic [MAG_W-1:0] LIMIT = MAG_W'((64'd1 << PK_W) - 64'd1);
      assign mag_sat = (mag > LIMIT) ? LIMIT[PK_W-1:0] : mag[PK_W-1:0];
    end else begin : g_pass
      assign mag_sat = PK_W'(mag);
    end
  endgenerate

  assign take_seen = acc_seen | hit;
  assign take_val  = hit ? peak_max(acc_val, mag_sat) : acc_val;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_val  <= '0;
      acc_seen <= 1'b0;
    end else if (clr) begin
      acc_val  <= '0;
      acc_seen <= 1'b0;
    end else if (hit) begin
      acc_val  <= take_val;
      acc_seen <= 1'b1;
    end
  end

  // R7: the running peak never drops between clears
  a_r7_never_below: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_seen && !clr) |=> (acc_val >= $past(acc_val)));

  // R8: a move empties the running peak
  a_r8_clear_on_move: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (!acc_seen && acc_val == '0));

endmodule

// File: rtl/pkr_snapshot.sv
module pkr_snapshot
  import pkr_pkg::*;
#(
  parameter int PK_W = 15
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              col_tick,
  input  logic                              arm,
  input  logic                              freeze,
  input  logic [NUM_CH-1:0][PK_W-1:0]       take_val,
  input  logic [NUM_CH-1:0]                 take_seen,
  output logic [NUM_CH-1:0][WORD_W-1:0]     snap_word,
  output logic                              xfer,
  output logic                              want
);

  function automatic logic [WORD_W-1:0] pack_word(input logic [PK_W-1:0] val,
                                                  input logic            seen);
    return seen ? WORD_W'({val, 1'b1}) : '0;
  endfunction

  assign xfer = col_tick && want && !freeze;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      want <= 1'b1;
    end else if (arm) begin
      want <= 1'b1;
    end else if (xfer) begin
      want <= 1'b0;
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        snap_word[c] <= '0;
      end else if (xfer) begin
        snap_word[c] <= pack_word(take_val[c], take_seen[c]);
      end
    end

    // R10: an empty channel leaves an all-zero word
    a_r10_empty_word: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer && !take_seen[c]) |=> (snap_word[c] == '0));

    // R6: a filled channel carries its valid flag in bit 0
    a_r6_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer && take_seen[c]) |=> snap_word[c][0]);
  end

  // R11: no move while a peak read is underway
  a_r11_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    freeze |=> $stable(snap_word));

  // R9: without a column tick the snapshot is unchanged
  a_r9_hold_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !col_tick |=> $stable(snap_word));

  // R8: a move consumes the pending request
  a_r8_want_clears: assert property (@(posedge clk) disable iff (!rst_n)
    xfer |=> !want);

endmodule

// File: rtl/pkr_rd_seq.sv
module pkr_rd_seq
  import pkr_pkg::*;
(
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          addr_wr,
  input  logic                          rd_stb,
  input  logic [7:0]                    stat_hi,
  input  logic [7:0]                    stat_lo,
  input  logic [NUM_CH-1:0][WORD_W-1:0] snap_word,
  output logic [7:0]                    rd_data,
  output seq_pos_t                      pos,
  output logic                          arm,
  output logic                          freeze
);

  logic accept;

  function automatic logic [7:0] pick_byte(input seq_pos_t p,
                                           input logic [7:0] hi,
                                           input logic [7:0] lo,
                                           input logic [NUM_CH-1:0][WORD_W-1:0] w);
    case (p)
      SQ_ST_HI: return hi;
      SQ_ST_LO: return lo;
      SQ_PK0:   return w[0][7:0];
      SQ_PK1:   return w[0][15:8];
      SQ_PK2:   return w[1][7:0];
      SQ_PK3:   return w[1][15:8];
      default:  return 8'h00;
    endcase
  endfunction

  assign accept = rd_stb && !addr_wr;
  assign arm    = accept && (pos == SQ_PK0);
  assign freeze = arm || (pos == SQ_PK1) || (pos == SQ_PK2) || (pos == SQ_PK3);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos <= SQ_ST_HI;
    end else if (addr_wr) begin
      pos <= SQ_ST_HI;
    end else if (accept && pos != SQ_DONE) begin
      pos <= seq_pos_t'(pos + 3'd1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data <= 8'h00;
    end else if (accept) begin
      rd_data <= pick_byte(pos, stat_hi, stat_lo, snap_word);
    end
  end

  // R1: an address write rewinds the sequence
  a_r1_rewind: assert property (@(posedge clk) disable iff (!rst_n)
    addr_wr |=> (pos == SQ_ST_HI));

  // R2: each accepted read moves one step
  a_r2_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && pos != SQ_DONE) |=> (3'(pos) == 3'($past(pos)) + 3'd1));

  // R3: the end position holds and returns zero
  a_r3_end_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (pos == SQ_DONE && !addr_wr) |=> (pos == SQ_DONE));
  a_r3_end_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (pos == SQ_DONE && accept) |=> (rd_data == 8'h00));

  // R12: the output byte only changes on an accepted read
  a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> $stable(rd_data));

endmodule

// File: rtl/pkr_readout.sv
module pkr_readout
  import pkr_pkg::*;
#(
  parameter int MAG_W = 16,
  parameter int PK_W  = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             addr_wr,
  input  logic             rd_stb,
  input  logic             col_tick,
  input  logic             smp_valid,
  input  logic             smp_chan,
  input  logic [MAG_W-1:0] smp_mag,
  input  logic [3:0]       st_bitrate,
  input  logic [1:0]       st_rate,
  input  logic             st_rdy_set,
  input  logic             st_rdy_ext,
  input  logic [1:0]       st_emph,
  input  logic [5:0]       st_misc,
  output logic [7:0]       rd_data
);

  logic [NUM_CH-1:0][PK_W-1:0]   acc_val;
  logic [NUM_CH-1:0]             acc_seen;
  logic [NUM_CH-1:0][PK_W-1:0]   take_val;
  logic [NUM_CH-1:0]             take_seen;
  logic [NUM_CH-1:0][WORD_W-1:0] snap_word;
  logic                          xfer;
  logic                          want;
  logic                          arm;
  logic                          freeze;
  seq_pos_t                      pos;
  logic [7:0]                    stat_hi;
  logic [7:0]                    stat_lo;

  assign stat_hi = status_hi(st_bitrate, st_rate, st_rdy_set, st_rdy_ext);
  assign stat_lo = status_lo(st_emph, st_misc);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic hit;
    assign hit = smp_valid && (smp_chan == c[0]);

    pkr_chan_acc #(.MAG_W(MAG_W), .PK_W(PK_W)) u_acc (
      .clk       (clk),
      .rst_n     (rst_n),
      .hit       (hit),
      .mag       (smp_mag),
      .clr       (xfer),
      .acc_val   (acc_val[c]),
      .acc_seen  (acc_seen[c]),
      .take_val  (take_val[c]),
      .take_seen (take_seen[c])
    );
  end

  pkr_snapshot #(.PK_W(PK_W)) u_snap (
    .clk       (clk),
    .rst_n     (rst_n),
    .col_tick  (col_tick),
    .arm       (arm),
    .freeze    (freeze),
    .take_val  (take_val),
    .take_seen (take_seen),
    .snap_word (snap_word),
    .xfer      (xfer),
    .want      (want)
  );

  pkr_rd_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .addr_wr   (addr_wr),
    .rd_stb    (rd_stb),
    .stat_hi   (stat_hi),
    .stat_lo   (stat_lo),
    .snap_word (snap_word),
    .rd_data   (rd_data),
    .pos       (pos),
    .arm       (arm),
    .freeze    (freeze)
  );

  // R8: a move only happens with a pending request
  a_r8_move_needs_want: assert property (@(posedge clk) disable iff (!rst_n)
    (col_tick && !want) |=> $stable(snap_word));

endmodule

// File: tb/test_pkr_readout.sv
`timescale 1ns/1ps
module test_pkr_readout;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        addr_wr = 1'b0, rd_stb = 1'b0, col_tick = 1'b0;
  logic        smp_valid = 1'b0, smp_chan = 1'b0;
  logic [15:0] smp_mag = '0;
  logic [3:0]  st_bitrate = 4'b1100;
  logic [1:0]  st_rate = 2'b00;
  logic        st_rdy_set = 1'b1, st_rdy_ext = 1'b0;
  logic [1:0]  st_emph = 2'b00;
  logic [5:0]  st_misc = 6'h15;
  logic [7:0]  rd_data;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;

  int          m_acc [2];
  bit          m_has [2];
  logic [15:0] m_snap [2];
  bit          m_want;
  int          m_cnt;
  logic [7:0]  m_last;

  always #2 clk = ~clk;

  pkr_readout i_pkr_readout (
    .clk(clk), .rst_n(rst_n), .addr_wr(addr_wr), .rd_stb(rd_stb),
    .col_tick(col_tick), .smp_valid(smp_valid), .smp_chan(smp_chan),
    .smp_mag(smp_mag), .st_bitrate(st_bitrate), .st_rate(st_rate),
    .st_rdy_set(st_rdy_set), .st_rdy_ext(st_rdy_ext), .st_emph(st_emph),
    .st_misc(st_misc), .rd_data(rd_data)
  );

  function automatic int clamp15(input int m);
    return (m > 32767) ? 32767 : m;
  endfunction

  function automatic logic [7:0] exp_byte(input int cnt);
    case (cnt)
      0: return {st_bitrate, st_rate, st_rdy_set, st_rdy_ext};
      1: return {st_emph, st_misc};
      2: return m_snap[0][7:0];
      3: return m_snap[0][15:8];
      4: return m_snap[1][7:0];
      5: return m_snap[1][15:8];
      default: return 8'h00;
    endcase
  endfunction

  function automatic string tag_of(input int cnt);
    case (cnt)
      0: return "R4";
      1: return "R5";
      2, 3, 4, 5: return "R6";
      default: return "R3";
    endcase
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: rd_data=%h expected %h", req, act, exp);
    end
  endtask

  task automatic op_addr();
    @(negedge clk); addr_wr = 1'b1;
    m_cnt = 0;
    @(negedge clk); addr_wr = 1'b0;
    check("R12 hold on addr", rd_data, m_last);
  endtask

  task automatic op_read(input string req);
    logic [7:0] e;
    @(negedge clk); rd_stb = 1'b1;
    e = exp_byte(m_cnt);
    if (m_cnt == 2) m_want = 1;
    if (m_cnt < 6) m_cnt++;
    m_last = e;
    @(negedge clk); rd_stb = 1'b0;
    check(req, rd_data, e);
  endtask

  task automatic op_read_auto();
    string t;
    t = tag_of(m_cnt);
    op_read(t);
  endtask

  task automatic op_sample(input bit ch, input int mag);
    @(negedge clk); smp_valid = 1'b1; smp_chan = ch; smp_mag = 16'(mag);
    m_has[ch] = 1;
    if (clamp15(mag) > m_acc[ch]) m_acc[ch] = clamp15(mag);
    @(negedge clk); smp_valid = 1'b0;
    check("R12 hold on sample", rd_data, m_last);
  endtask

  task automatic model_tick();
    if (m_want && !(m_cnt >= 3 && m_cnt <= 5)) begin
      for (int c = 0; c < 2; c++) begin
        m_snap[c] = m_has[c] ? {15'(m_acc[c]), 1'b1} : 16'h0000;
        m_acc[c] = 0;
        m_has[c] = 0;
      end
      m_want = 0;
    end
  endtask

  task automatic op_tick();
    @(negedge clk); col_tick = 1'b1;
    model_tick();
    @(negedge clk); col_tick = 1'b0;
    check("R12 hold on tick", rd_data, m_last);
  endtask

  task automatic read_all(input string req);
    op_addr();
    for (int k = 0; k < 6; k++) begin
      if (k < 2) op_read_auto(); else op_read(req);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog: run did not end, actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7041));
    for (int c = 0; c < 2; c++) begin
      m_acc[c] = 0; m_has[c] = 0; m_snap[c] = 16'h0000;
    end
    m_want = 1; m_cnt = 0; m_last = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R12 reset value", rd_data, 8'h00);

    // R10: no snapshot yet, all peak bytes zero; R3 past the end
    read_all("R10");
    op_read("R3");
    op_read("R3");

    // R7 clamp and max; R8 move on tick
    op_sample(0, 100);
    op_sample(0, 65535);
    op_sample(0, 5);
    op_sample(1, 300);
    op_sample(1, 299);
    op_tick();
    read_all("R8");
    check("R7 clamp ch0 word", m_snap[0][7:0], 8'hFF);

    // R9: early reread repeats snapshot even with new samples
    op_sample(1, 12345);
    read_all("R9");

    // R10: channel 0 empty in this period
    op_tick();
    read_all("R10");

    // R11: tick during a peak read does not change snapshot
    op_sample(0, 777);
    op_addr();
    op_read_auto(); op_read_auto(); op_read("R11");
    op_sample(0, 999);
    op_tick();
    op_read("R11"); op_read("R11"); op_read("R11");
    op_tick();
    read_all("R11");

    // R5: status bytes sampled at separate instants; R4 layout
    op_addr();
    st_rate = 2'b01; st_rdy_ext = 1'b1;
    op_read("R4");
    st_emph = 2'b10; st_misc = 6'h2A; st_rate = 2'b10;
    op_read("R5");
    op_addr();
    op_read("R4");

    // R1: address write with a read in the same cycle ignores the read
    op_read("R5");
    @(negedge clk); addr_wr = 1'b1; rd_stb = 1'b1;
    m_cnt = 0;
    @(negedge clk); addr_wr = 1'b0; rd_stb = 1'b0;
    check("R1 read ignored with addr", rd_data, m_last);
    op_read("R1");

    // R8: sample in the same cycle as a qualifying tick is included
    read_all("R8");
    @(negedge clk); col_tick = 1'b1; smp_valid = 1'b1; smp_chan = 1'b0; smp_mag = 16'd4242;
    m_has[0] = 1; if (4242 > m_acc[0]) m_acc[0] = 4242;
    model_tick();
    @(negedge clk); col_tick = 1'b0; smp_valid = 1'b0;
    read_all("R8");

    // random mix, R2 ordering checked by every read
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = int'($urandom_range(99));
      if (r < 40) begin
        int mg;
        mg = ($urandom_range(3) == 0) ? int'($urandom_range(65535)) : int'($urandom_range(40000));
        op_sample(1'($urandom_range(1)), mg);
      end else if (r < 55) begin
        op_tick();
      end else if (r < 85) begin
        op_read_auto();
      end else if (r < 95) begin
        op_addr();
      end else begin
        st_bitrate = ($urandom_range(3) == 0) ? 4'($urandom_range(15)) : 4'b1100;
        st_rate = 2'($urandom_range(3));
        st_rdy_set = 1'($urandom_range(1));
        st_rdy_ext = 1'($urandom_range(1));
        st_emph = 2'($urandom_range(3));
        st_misc = 6'($urandom_range(63));
        @(negedge clk);
        check("R12 hold on status change", rd_data, m_last);
      end
    end
    read_all("R2");

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_fail, n_checks);
    $finish;
  end

endmodule